// File: doc/BRIEF.md
# Nibble-Gated Binary Counter

A synchronous 16-bit up-counter split into four 4-bit stages that all draw on one source clock. No stage has a data-path enable. Each stage is clocked through its own glitch-free gating cell, so a stage's flip-flops see a clock edge only in cycles when they must advance. When counting runs without a pause, the lowest stage is clocked on every source edge. The second stage is clocked once every 16 source edges, the third once every 256 and the top stage once every 4096.

The gating term for each upper stage comes directly from the carry of the stage below: that stage's own gate term ANDed with all four of its bits. No separate activity-detection logic is needed, and the carry chain serves as both the count logic and the clock-gating logic. A global count enable drives the lowest stage's gate. While it is low, every gate in the chain is closed and the count holds. A terminal-count flag is high in the cycle whose next edge wraps the count from all ones back to zero. The active-low reset is asynchronous and clears every stage, whether or not its clock is running.

Top module: `nibble_gated_counter`

## Requirements
- R1: While rst_n is low, count is 0 and tc is 0.
- R2: On each rising source clock edge with count_en high, count becomes (count + 1) mod 65536, so 65535 is followed by 0.
- R3: For stage k of 1 to 3 (count bits 4k+3 to 4k), the nibble changes only on an enabled edge where all count bits below bit 4k are 1. Its gated clock pulses exactly floor(E / 16^k) times after E enabled edges since reset.
- R4: The lowest nibble (bits 3 to 0) advances by one, modulo 16, on every enabled edge. Its clock pulses once per enabled edge.
- R5: On a rising edge with count_en low, all 16 bits of count hold their value.
- R6: tc is high exactly when count_en is high and count is 65535. The edge that follows brings count to 0.
- R7: Pulling rst_n low at any time clears count to 0 at once, without waiting for a clock edge. This applies even to stages whose gated clock is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock shared by all stages |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_en | input | 1 | Global count enable; low closes every stage's clock gate |
| count | output | 16 | Current count, nibble 0 in bits 3 to 0 |
| tc | output | 1 | Terminal count: enable high and count at all ones |

## Verification
Every nibble takes its new value on the rising source edge at which its gate was open. The bench drives inputs 5 ns after a rising edge and compares all four nibbles and tc with a behavioural reference at the following falling edge. That is half a cycle after the edge that updated the count. tc is combinational, so it is due in the same half-cycle as the count it depends on. Reset is the exception: its effect is due immediately, and the bench samples it 1 ns after rst_n falls, between clock edges. The gated-clock pulse counts are compared at each falling edge, after that cycle's pulses have finished.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  localparam int NIB_W = 4;

  typedef logic [NIB_W-1:0] nib_t;

  // true when every bit of the nibble is set (its carry condition)
  function automatic logic nib_full(input nib_t q);
    return &q;
  endfunction

  // next value of a nibble, wrapping at 2**NIB_W
  function automatic nib_t nib_inc(input nib_t q);
    return q + nib_t'(1);
  endfunction
endpackage

// File: rtl/cnt_clk_gate.sv
// Latch-based clock gate: the enable passes while the clock is low and is
// frozen while the clock is high, so the gated clock never glitches.
module cnt_clk_gate (
  input  logic clk,
  input  logic en,
  output logic gclk
);
  logic en_held;

  always_latch begin
    if (!clk) en_held <= en;
  end

  assign gclk = clk & en_held;
endmodule

// File: rtl/cnt_nibble_stage.sv
// One 4-bit stage: its own clock gate plus a nibble register that
// increments on every edge of the gated clock.
module cnt_nibble_stage
  import cnt_pkg::*;
(
  input  logic src_clk,
  input  logic rst_n,
  input  logic gate_en,
  output nib_t q,
  output logic carry_out,
  output logic gclk
);
  cnt_clk_gate u_gate (
    .clk  (src_clk),
    .en   (gate_en),
    .gclk (gclk)
  );

  always_ff @(posedge gclk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nib_inc(q);
  end

  assign carry_out = gate_en & nib_full(q);
endmodule

// File: rtl/nibble_gated_counter.sv
module nibble_gated_counter #(
  parameter int NIBBLES = 4,
  localparam int NIB_W  = cnt_pkg::NIB_W,
  localparam int W      = NIBBLES * NIB_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         count_en,
  output logic [W-1:0] count,
  output logic         tc
);
  // named internal events for the checker
  logic [NIBBLES-1:0] stage_en;
  logic [NIBBLES-1:0] stage_carry;
  logic [NIBBLES-1:0] stage_gclk;

  assign stage_en[0] = count_en;

  genvar k;
  generate
    for (k = 0; k < NIBBLES; k++) begin : g_stage
      cnt_pkg::nib_t q_k;

      if (k > 0) begin : g_chain
        assign stage_en[k] = stage_carry[k-1];
      end

      cnt_nibble_stage u_stage (
        .src_clk   (clk),
        .rst_n     (rst_n),
        .gate_en   (stage_en[k]),
        .q         (q_k),
        .carry_out (stage_carry[k]),
        .gclk      (stage_gclk[k])
      );

      assign count[k*NIB_W +: NIB_W] = q_k;
    end
  endgenerate

  assign tc = stage_carry[NIBBLES-1];
endmodule

// File: rtl/nibble_gated_counter_chk.sv
module nibble_gated_counter_chk #(
  parameter int NIBBLES = 4,
  localparam int NIB_W  = cnt_pkg::NIB_W,
  localparam int W      = NIBBLES * NIB_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               count_en,
  input logic [W-1:0]       count,
  input logic               tc,
  input logic [NIBBLES-1:0] stage_gclk
);
  logic [31:0] en_cycles;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        en_cycles <= '0;
    else if (count_en) en_cycles <= en_cycles + 32'd1;
  end

  AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    count_en |=> count == W'($past(count) + 1'b1)); // R2

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !count_en |=> $stable(count)); // R5

  AST_TC_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    tc == (count_en && (&count))); // R6

  AST_TC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> count == '0); // R6

  genvar k;
  generate
    for (k = 0; k < NIBBLES; k++) begin : g_pulse
      logic [31:0] pulse_cnt;

      always_ff @(posedge stage_gclk[k] or negedge rst_n) begin
        if (!rst_n) pulse_cnt <= '0;
        else        pulse_cnt <= pulse_cnt + 32'd1;
      end

      AST_PULSE_RATE: assert property (@(negedge clk) disable iff (!rst_n)
        pulse_cnt == (en_cycles >> (NIB_W * k))); // R3

      if (k > 0) begin : g_upper
        AST_UPPER_STILL: assert property (@(posedge clk) disable iff (!rst_n)
          !(count_en && (&count[k*NIB_W-1:0]))
          |=> $stable(count[k*NIB_W +: NIB_W])); // R3

        AST_GCLK_ON_WRAP: assert property (@(negedge clk) disable iff (!rst_n)
          stage_gclk[k] |-> count[k*NIB_W-1:0] == '0); // R3
      end
    end
  endgenerate
endmodule

bind nibble_gated_counter nibble_gated_counter_chk #(.NIBBLES(NIBBLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .count_en   (count_en),
  .count      (count),
  .tc         (tc),
  .stage_gclk (stage_gclk)
);

// File: tb/tb_nibble_gated_counter.sv
`timescale 1ns/1ps
module tb_nibble_gated_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        count_en = 1'b0;
  logic [15:0] count;
  logic        tc;

  int n_cmp = 0;
  int n_bad = 0;
  int ref_cnt = 0;
  int prev_cnt = 0;
  bit prev_en = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  nibble_gated_counter dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_en (count_en),
    .count    (count),
    .tc       (tc)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: plain integer counter
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ref_cnt <= 0;
    else if (count_en) ref_cnt <= (ref_cnt + 1) % 65536;
  end

  // compare on every falling edge, half a cycle after the update
  always @(negedge clk) begin
    if (!done) begin
      int exp_tc;
      exp_tc = (count_en && ref_cnt == 65535) ? 1 : 0;
      if (!rst_n) begin
        chk(count == 16'd0, "R1 count in reset", count, 0);
        chk(tc == 1'b0, "R1 tc in reset", tc, 0);
      end else begin
        chk(count[3:0] == ref_cnt[3:0], "R4 nibble0", count[3:0], ref_cnt[3:0]);
        for (int k = 1; k < 4; k++)
          chk(count[k*4 +: 4] == ref_cnt[k*4 +: 4], "R3 upper nibble",
              count[k*4 +: 4], ref_cnt[k*4 +: 4]);
        chk(count == ref_cnt[15:0], "R2 count", count, ref_cnt);
        chk(tc == exp_tc[0], "R6 tc", tc, exp_tc);
        if (!prev_en)
          chk(count == prev_cnt[15:0], "R5 hold", count, prev_cnt);
        if (prev_en && prev_cnt == 65535)
          chk(count == 16'd0, "R6 wrap to zero", count, 0);
      end
      prev_cnt = count;
    end
  end

  always @(posedge clk) prev_en <= count_en;

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #5;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    step(3);                       // R1 checks during reset
    rst_n = 1'b1;
    step(2);
    count_en = 1'b1; step(40);     // R2 R4 plain counting
    count_en = 1'b0; step(10);     // R5 freeze
    for (int i = 0; i < 100; i++) begin
      count_en = (i % 3) != 0;     // irregular enable pattern
      step(1);
    end
    count_en = 1'b1;
    step(65600);                   // full wrap: R3 R6
    count_en = 1'b0; step(3);
    // R7: asynchronous reset in the middle of a count
    rst_n = 1'b0;
    #1;
    chk(count == 16'd0, "R7 async clear", count, 0);
    chk(tc == 1'b0, "R7 tc clear", tc, 0);
    step(2);
    rst_n = 1'b1;
    count_en = 1'b1; step(300);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule